// File: doc/BRIEF.md
# Single-Cycle Memory-to-Memory Processor Core

This block is a small Harvard-architecture processor. It has no data register file. Every operand lives in an 8-bit data RAM of up to 256 words, and programs sit in a separate instruction ROM of up to 256 words of 24 bits. Each clock the core does the following:

- fetches the word addressed by its program counter;
- decodes it and forms up to two effective addresses, either taken as given or offset by a base register;
- reads both operands through two combinational RAM read ports;
- computes the result and writes it back through one synchronous write port;
- updates its four condition flags and the program counter.

The core is placed next to an asynchronous-read ROM and a two-read, one-write RAM that the surrounding design provides. The architectural state is the program counter, the base register and the flags sign, zero, carry and overflow. That state is visible only through the memory traffic the core produces and through the addresses it fetches.

Top module: `mm_core`

## Requirements
- R1: While `rst_n` is low, the program counter, the base register and all four flags are zero, `imem_addr` is 0 and `dmem_we` is 0. The first instruction after release is fetched from address 0.
- R2: The instruction word is split into fields. Bits [23:19] are the opcode, bit 18 is `r` and bit 17 is `s`. Bit 16 is unused. Bits [15:8] are `a1` and bits [7:0] are `a2`. Opcodes 1 to 9 are, in order: ADD, ADC, SUB, CMP, SBB, AND, TEST, OR and XOR. Except CMP and TEST, these write M[ea1] op M[ea2] to ea1 in the same cycle. ADC adds the carry flag. SUB computes a + ~b + 1. SBB computes a + ~b + ~C.
- R3: Every opcode from 1 to 15 loads the flags from its result, packed as {S,Z,C,V} with S in bit 3 and V in bit 0. S is bit 7 of the result, and Z is set when the result is zero.
  - For additions, C is the carry out and V is signed overflow.
  - For SUB, CMP and SBB, C is the borrow, which is the inverted carry out, and V is signed overflow of a + ~b + cin.
  - For AND, TEST, OR, XOR and NOT, both C and V are cleared.
- R4: CMP (4) and TEST (7) update the flags and never assert `dmem_we`.
- R5: STORE (16) writes the `a2` byte to ea1 and leaves the flags unchanged.
- R6: NOT (10) writes the complement of M[ea2] back to ea2.
- R7: The shifts update ea1 and set C to the bit shifted out:
  - RL (11) shifts left and fills a 0.
  - RR (12) shifts right and fills a 0.
  - RLC (13) shifts left and fills the old C.
  - RRC (14) shifts right and fills the old C.
  - RRA (15) shifts right and keeps bit 7.
  - V is cleared by all five.
- R8: ea1 is a1+BAR when `r` is set and a1 otherwise, modulo 256. ea2 is formed the same way from a2 and `s`. SETBAR (17) loads BAR from M[ea2] and writes no memory.
- R9: BR (18) jumps to ea1 when any flag selected by the mask `a2[3:0]` is set. BRN (19) jumps when any selected flag is clear. Otherwise both continue at PC+1, and neither writes memory.
- R10: Opcode 0 and opcodes 20 to 31 write nothing, keep the flags and the base register, and advance the PC.
- R11: Apart from a taken branch, the PC advances by one each cycle and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 8 | Instruction fetch address (program counter) |
| imem_data | input | 24 | Instruction word returned combinationally |
| dmem_raddr_a | output | 8 | Read address for ea1 |
| dmem_rdata_a | input | 8 | Data at ea1 |
| dmem_raddr_b | output | 8 | Read address for ea2 |
| dmem_rdata_b | input | 8 | Data at ea2 |
| dmem_we | output | 1 | Write enable, taken on the rising clock edge |
| dmem_waddr | output | 8 | Write address |
| dmem_wdata | output | 8 | Write data |

## Verification
A hand-written program is run first, with values chosen to hit the corners:
- signed overflow on 0x7F+0x01;
- borrow in and out on SBB;
- carry rotated through RLC and RRC;
- a compare of a word with itself;
- a countdown loop that ends on the zero flag;
- a jump that runs the PC through address 255 and back to 0.

This run separates faults in the flag formulas and the branch mask polarity, which only show up in later control flow, from faults in the datapath. A second run loads a random program and random RAM, so every opcode, including the undefined ones, meets arbitrary base offsets and flag states. A reset in the middle of the run shows that the fetch address and the write enable return to idle at once.

// File: rtl/mm_core_pkg.sv
package mm_core_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int OPC_W   = 5;
    localparam int INSTR_W = OPC_W + 3 + 2 * ADDR_W;
    localparam int MASK_W  = 4;

    localparam logic [OPC_W-1:0] OP_ADD    = 5'd1;
    localparam logic [OPC_W-1:0] OP_ADC    = 5'd2;
    localparam logic [OPC_W-1:0] OP_SUB    = 5'd3;
    localparam logic [OPC_W-1:0] OP_CMP    = 5'd4;
    localparam logic [OPC_W-1:0] OP_SBB    = 5'd5;
    localparam logic [OPC_W-1:0] OP_AND    = 5'd6;
    localparam logic [OPC_W-1:0] OP_TEST   = 5'd7;
    localparam logic [OPC_W-1:0] OP_OR     = 5'd8;
    localparam logic [OPC_W-1:0] OP_XOR    = 5'd9;
    localparam logic [OPC_W-1:0] OP_NOT    = 5'd10;
    localparam logic [OPC_W-1:0] OP_RL     = 5'd11;
    localparam logic [OPC_W-1:0] OP_RR     = 5'd12;
    localparam logic [OPC_W-1:0] OP_RLC    = 5'd13;
    localparam logic [OPC_W-1:0] OP_RRC    = 5'd14;
    localparam logic [OPC_W-1:0] OP_RRA    = 5'd15;
    localparam logic [OPC_W-1:0] OP_STORE  = 5'd16;
    localparam logic [OPC_W-1:0] OP_SETBAR = 5'd17;
    localparam logic [OPC_W-1:0] OP_BR     = 5'd18;
    localparam logic [OPC_W-1:0] OP_BRN    = 5'd19;

    // Field order matches the branch mask bit order: s=3 .. v=0
    typedef struct packed {
        logic s;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic [OPC_W-1:0]  op;
        logic              rel1;
        logic              rel2;
        logic [ADDR_W-1:0] f1;
        logic [ADDR_W-1:0] f2;
        logic              wr_ea1;
        logic              wr_ea2;
        logic              upd_flags;
        logic              wr_imm;
        logic              ld_base;
        logic              branch;
        logic              br_inv;
    } dec_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] base;
        flags_t            fl;
    } core_st_t;
endpackage

// File: rtl/mm_core_decode.sv
module mm_core_decode
    import mm_core_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic unused_spare;
    assign unused_spare = instr[2*ADDR_W];

    always_comb begin
        dec      = '0;
        dec.op   = instr[INSTR_W-1 -: OPC_W];
        dec.rel1 = instr[INSTR_W-OPC_W-1];
        dec.rel2 = instr[INSTR_W-OPC_W-2];
        dec.f1   = instr[2*ADDR_W-1:ADDR_W];
        dec.f2   = instr[ADDR_W-1:0];
        case (dec.op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_AND, OP_OR, OP_XOR,
            OP_RL, OP_RR, OP_RLC, OP_RRC, OP_RRA: begin
                dec.wr_ea1    = 1'b1;
                dec.upd_flags = 1'b1;
            end
            OP_CMP, OP_TEST: dec.upd_flags = 1'b1;
            OP_NOT: begin
                dec.wr_ea2    = 1'b1;
                dec.upd_flags = 1'b1;
            end
            OP_STORE: begin
                dec.wr_ea1 = 1'b1;
                dec.wr_imm = 1'b1;
            end
            OP_SETBAR: dec.ld_base = 1'b1;
            OP_BR:     dec.branch  = 1'b1;
            OP_BRN: begin
                dec.branch = 1'b1;
                dec.br_inv = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mm_core_agu.sv
module mm_core_agu
    import mm_core_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic              rel1,
    input  logic              rel2,
    input  logic [ADDR_W-1:0] f1,
    input  logic [ADDR_W-1:0] f2,
    output logic [ADDR_W-1:0] ea1,
    output logic [ADDR_W-1:0] ea2
);
    localparam int NPORT = 2;
    logic [ADDR_W-1:0] fld [NPORT];
    logic              rel [NPORT];
    logic [ADDR_W-1:0] ea  [NPORT];

    assign fld[0] = f1;
    assign fld[1] = f2;
    assign rel[0] = rel1;
    assign rel[1] = rel2;

    for (genvar i = 0; i < NPORT; i++) begin : g_ea
        assign ea[i] = rel[i] ? (fld[i] + base) : fld[i];
    end

    assign ea1 = ea[0];
    assign ea2 = ea[1];
endmodule

// File: rtl/mm_core_alu.sv
module mm_core_alu
    import mm_core_pkg::*;
(
    input  logic [OPC_W-1:0]  op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  flags_t            fl_in,
    output logic [DATA_W-1:0] res,
    output flags_t            fl_out
);
    logic [DATA_W-1:0] addb;
    logic              cin;
    logic              is_sub;
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] low;
    logic              cf;
    logic              vf;

    always_comb begin
        addb   = b;
        cin    = 1'b0;
        is_sub = 1'b0;
        case (op)
            OP_ADC: cin = fl_in.c;
            OP_SUB, OP_CMP: begin
                addb   = ~b;
                cin    = 1'b1;
                is_sub = 1'b1;
            end
            OP_SBB: begin
                addb   = ~b;
                cin    = ~fl_in.c;
                is_sub = 1'b1;
            end
            default: ;
        endcase

        sum = {1'b0, a} + {1'b0, addb} + {{DATA_W{1'b0}}, cin};
        low = {1'b0, a[DATA_W-2:0]} + {1'b0, addb[DATA_W-2:0]}
            + {{(DATA_W-1){1'b0}}, cin};

        res = a;
        cf  = 1'b0;
        vf  = 1'b0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_CMP, OP_SBB: begin
                res = sum[DATA_W-1:0];
                cf  = sum[DATA_W] ^ is_sub;
                vf  = low[DATA_W-1] ^ sum[DATA_W];
            end
            OP_AND, OP_TEST: res = a & b;
            OP_OR:           res = a | b;
            OP_XOR:          res = a ^ b;
            OP_NOT:          res = ~b;
            OP_RL: begin
                res = {a[DATA_W-2:0], 1'b0};
                cf  = a[DATA_W-1];
            end
            OP_RR: begin
                res = {1'b0, a[DATA_W-1:1]};
                cf  = a[0];
            end
            OP_RLC: begin
                res = {a[DATA_W-2:0], fl_in.c};
                cf  = a[DATA_W-1];
            end
            OP_RRC: begin
                res = {fl_in.c, a[DATA_W-1:1]};
                cf  = a[0];
            end
            OP_RRA: begin
                res = {a[DATA_W-1], a[DATA_W-1:1]};
                cf  = a[0];
            end
            default: ;
        endcase

        fl_out.s = res[DATA_W-1];
        fl_out.z = (res == '0);
        fl_out.c = cf;
        fl_out.v = vf;
    end
endmodule

// File: rtl/mm_core.sv
module mm_core
    import mm_core_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    output logic [ADDR_W-1:0]  imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic [ADDR_W-1:0]  dmem_raddr_a,
    input  logic [DATA_W-1:0]  dmem_rdata_a,
    output logic [ADDR_W-1:0]  dmem_raddr_b,
    input  logic [DATA_W-1:0]  dmem_rdata_b,
    output logic               dmem_we,
    output logic [ADDR_W-1:0]  dmem_waddr,
    output logic [DATA_W-1:0]  dmem_wdata
);
    core_st_t          st_q, st_d;
    dec_t              dec;
    logic [ADDR_W-1:0] ea1, ea2;
    logic [DATA_W-1:0] alu_res;
    flags_t            alu_fl;
    flags_t            sel_fl;
    logic              br_hit;

    mm_core_decode u_dec (
        .instr (imem_data),
        .dec   (dec)
    );

    mm_core_agu u_agu (
        .base (st_q.base),
        .rel1 (dec.rel1),
        .rel2 (dec.rel2),
        .f1   (dec.f1),
        .f2   (dec.f2),
        .ea1  (ea1),
        .ea2  (ea2)
    );

    mm_core_alu u_alu (
        .op     (dec.op),
        .a      (dmem_rdata_a),
        .b      (dmem_rdata_b),
        .fl_in  (st_q.fl),
        .res    (alu_res),
        .fl_out (alu_fl)
    );

    assign imem_addr    = st_q.pc;
    assign dmem_raddr_a = ea1;
    assign dmem_raddr_b = ea2;
    assign dmem_we      = (dec.wr_ea1 | dec.wr_ea2) & rst_n;
    assign dmem_waddr   = dec.wr_ea2 ? ea2 : ea1;
    assign dmem_wdata   = dec.wr_imm ? dec.f2 : alu_res;

    always_comb begin
        sel_fl = dec.br_inv ? ~st_q.fl : st_q.fl;
        br_hit = dec.branch & (|(sel_fl & dec.f2[MASK_W-1:0]));

        st_d    = st_q;
        st_d.pc = br_hit ? ea1 : (st_q.pc + 1'b1);
        if (dec.upd_flags) st_d.fl   = alu_fl;
        if (dec.ld_base)   st_d.base = dmem_rdata_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mm_core_chk.sv
module mm_core_chk
    import mm_core_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] imem_addr,
    input logic [OPC_W-1:0]  i_op,
    input logic              i_rel1,
    input logic [ADDR_W-1:0] i_f1,
    input logic [ADDR_W-1:0] i_f2,
    input logic [ADDR_W-1:0] dmem_raddr_a,
    input logic [ADDR_W-1:0] dmem_raddr_b,
    input logic [DATA_W-1:0] dmem_rdata_b,
    input logic              dmem_we,
    input logic [ADDR_W-1:0] dmem_waddr,
    input logic [DATA_W-1:0] dmem_wdata
);
    logic two_op_wr;
    assign two_op_wr = (i_op >= OP_ADD) && (i_op <= OP_XOR)
                    && (i_op != OP_CMP) && (i_op != OP_TEST);

    AST_TWO_OP_WRITES_EA1: assert property (@(posedge clk) disable iff (!rst_n)
        two_op_wr |-> (dmem_we && dmem_waddr == dmem_raddr_a)); // R2

    AST_CMP_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (i_op == OP_CMP || i_op == OP_TEST) |-> !dmem_we); // R4

    AST_STORE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (i_op == OP_STORE) |-> (dmem_we && dmem_wdata == i_f2 && dmem_waddr == dmem_raddr_a)); // R5

    AST_NOT_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (i_op == OP_NOT) |-> (dmem_we && dmem_waddr == dmem_raddr_b
                              && dmem_wdata == ~dmem_rdata_b)); // R6

    AST_ABSOLUTE_EA1: assert property (@(posedge clk) disable iff (!rst_n)
        !i_rel1 |-> (dmem_raddr_a == i_f1)); // R8

    AST_SETBAR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (i_op == OP_SETBAR || i_op == OP_BR || i_op == OP_BRN) |-> !dmem_we); // R9

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (i_op != OP_BR && i_op != OP_BRN)
        |=> (imem_addr == ADDR_W'($past(imem_addr) + 1'b1))); // R11
endmodule

bind mm_core mm_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .imem_addr    (imem_addr),
    .i_op         (imem_data[INSTR_W-1 -: OPC_W]),
    .i_rel1       (imem_data[INSTR_W-OPC_W-1]),
    .i_f1         (imem_data[2*ADDR_W-1:ADDR_W]),
    .i_f2         (imem_data[ADDR_W-1:0]),
    .dmem_raddr_a (dmem_raddr_a),
    .dmem_raddr_b (dmem_raddr_b),
    .dmem_rdata_b (dmem_rdata_b),
    .dmem_we      (dmem_we),
    .dmem_waddr   (dmem_waddr),
    .dmem_wdata   (dmem_wdata)
);

// File: tb/mm_core_tb.sv
`timescale 1ns/1ps
module mm_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  imem_addr;
    logic [23:0] imem_data;
    logic [7:0]  dmem_raddr_a, dmem_raddr_b;
    logic [7:0]  dmem_rdata_a, dmem_rdata_b;
    logic        dmem_we;
    logic [7:0]  dmem_waddr, dmem_wdata;

    logic [23:0] rom [256];
    logic [7:0]  ram [256];

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    int ref_pc, ref_bar;
    bit fs, fz, fc, fv;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    assign imem_data    = rom[imem_addr];
    assign dmem_rdata_a = ram[dmem_raddr_a];
    assign dmem_rdata_b = ram[dmem_raddr_b];

    mm_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_raddr_a(dmem_raddr_a), .dmem_rdata_a(dmem_rdata_a),
        .dmem_raddr_b(dmem_raddr_b), .dmem_rdata_b(dmem_rdata_b),
        .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (pc %0d, t=%0t)",
                     tag, act, exp, ref_pc, $time);
        end
    endtask

    function automatic logic [23:0] enc(int op, bit r, bit s, int a1, int a2);
        return {5'(op), r, s, 1'b0, 8'(a1), 8'(a2)};
    endfunction

    task automatic ref_reset();
        ref_pc = 0; ref_bar = 0;
        fs = 0; fz = 0; fc = 0; fv = 0;
    endtask

    // One cycle of the reference model, compared against the ports,
    // then the memory write is applied after the clock edge.
    task automatic step();
        int ins, op, ea1, ea2, a, b, y, t, res, npc, mask, fl;
        bit we, setf, nc, nv, is_arith;
        string tag;
        ins = rom[ref_pc];
        op  = (ins >> 19) & 31;
        ea1 = ((ins >> 18) & 1) ? (((ins >> 8) & 255) + ref_bar) & 255 : (ins >> 8) & 255;
        ea2 = ((ins >> 17) & 1) ? ((ins & 255) + ref_bar) & 255 : ins & 255;
        a = ram[ea1]; b = ram[ea2];
        we = 0; setf = 0; res = 0; nc = 0; nv = 0; is_arith = 0;
        npc = (ref_pc + 1) & 255;
        tag = "R10";
        y = b;
        case (op)
            1: begin y = b;       t = a + y;            is_arith = 1; nc = t > 255; end
            2: begin y = b;       t = a + y + int'(fc); is_arith = 1; nc = t > 255; end
            3, 4: begin y = 255 - b; t = a + y + 1;     is_arith = 1; nc = !(t > 255); end
            5: begin y = 255 - b; t = a + y + (fc ? 0 : 1); is_arith = 1; nc = !(t > 255); end
            6, 7: res = a & b;
            8:  res = a | b;
            9:  res = a ^ b;
            10: res = 255 - b;
            11: begin res = (a << 1) & 255;           nc = a[7]; end
            12: begin res = a >> 1;                   nc = a[0]; end
            13: begin res = ((a << 1) & 255) | int'(fc); nc = a[7]; end
            14: begin res = (a >> 1) | (fc ? 128 : 0); nc = a[0]; end
            15: begin res = (a >> 1) | (a & 128);     nc = a[0]; end
            default: ;
        endcase
        if (is_arith) begin
            res = t & 255;
            nv = (((a ^ res) & (y ^ res) & 128) != 0);
        end
        if (op >= 1 && op <= 15) setf = 1;
        if ((op >= 1 && op <= 9) && op != 4 && op != 7) begin we = 1; tag = "R2"; end
        if (op == 4 || op == 7) tag = "R4";
        if (op == 10) begin we = 1; tag = "R6"; end
        if (op >= 11 && op <= 15) begin we = 1; tag = "R7"; end
        if (op == 16) begin we = 1; res = ins & 255; tag = "R5"; end
        if (op == 17) begin ref_bar = b; tag = "R8"; end
        if (op == 18 || op == 19) begin
            tag  = "R9";
            mask = ins & 15;
            fl   = (int'(fs) << 3) | (int'(fz) << 2) | (int'(fc) << 1) | int'(fv);
            if (op == 19) fl = ~fl & 15;
            if ((mask & fl) != 0) npc = ea1;
        end
        // R11: fetch address tracks the reference program counter
        chk("R11 fetch", imem_addr, ref_pc);
        chk({tag, " we"}, dmem_we, we);
        if (we) begin
            chk({tag, " waddr"}, dmem_waddr, (op == 10) ? ea2 : ea1);
            chk({tag, "/R3 wdata"}, dmem_wdata, res);
        end
        if (setf) begin  // R3 flag update
            fs = res[7]; fz = (res == 0); fc = nc; fv = nv;
        end
        ref_pc = npc;
        begin
            bit   w  = dmem_we;
            int   wa = dmem_waddr;
            int   wd = dmem_wdata;
            @(posedge clk);
            #1;
            if (w) ram[wa] = 8'(wd);
        end
        @(negedge clk);
        #1;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin rom[i] = '0; ram[i] = '0; end
        // directed program
        rom[0]  = enc(16, 0, 0, 8'h10, 8'h7F);
        rom[1]  = enc(16, 0, 0, 8'h11, 8'h01);
        rom[2]  = enc(1,  0, 0, 8'h10, 8'h11);  // 0x80, S=1 V=1
        rom[3]  = enc(18, 0, 0, 5,     8'h08);  // BR on S -> 5
        rom[4]  = enc(16, 0, 0, 8'h30, 8'hEE);  // skipped
        rom[5]  = enc(19, 0, 0, 4,     8'h01);  // BRN on V, not taken
        rom[6]  = enc(16, 0, 0, 8'h12, 8'h40);
        rom[7]  = enc(17, 0, 0, 0,     8'h12);  // BAR <- 0x40
        rom[8]  = enc(16, 1, 0, 8'h05, 8'h5A);  // M[0x45] <- 0x5A
        rom[9]  = enc(4,  1, 0, 8'h05, 8'h45);  // CMP equal
        rom[10] = enc(7,  0, 0, 8'h10, 8'h11);
        rom[11] = enc(10, 0, 0, 0,     8'h11);
        rom[12] = enc(15, 0, 0, 8'h10, 0);
        rom[13] = enc(13, 0, 0, 8'h10, 0);
        rom[14] = enc(2,  0, 0, 8'h11, 8'h12);
        rom[15] = enc(5,  0, 0, 8'h12, 8'h11);
        rom[16] = enc(8,  0, 0, 8'h12, 8'h10);
        rom[17] = enc(9,  0, 0, 8'h12, 8'h11);
        rom[18] = enc(6,  0, 0, 8'h12, 8'h10);
        rom[19] = enc(11, 0, 0, 8'h12, 0);
        rom[20] = enc(14, 0, 0, 8'h11, 0);
        rom[21] = enc(12, 0, 0, 8'h11, 0);
        rom[22] = enc(3,  0, 0, 8'h11, 8'h10);
        rom[23] = enc(31, 0, 0, 8'h11, 8'h11);  // undefined
        rom[24] = enc(16, 0, 0, 8'h20, 3);
        rom[25] = enc(16, 0, 0, 8'h21, 1);
        rom[26] = enc(3,  0, 0, 8'h20, 8'h21);
        rom[27] = enc(19, 0, 0, 26,    8'h04);  // loop until Z
        rom[28] = enc(18, 0, 0, 0,     8'h00);  // empty mask
        rom[29] = enc(19, 0, 0, 250,   8'h0F);  // taken -> 250
        for (int i = 250; i < 256; i++) rom[i] = enc(16, 0, 0, 8'h50 + i - 250, i - 250);

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset fetch", imem_addr, 0);
        chk("R1 reset we", dmem_we, 0);
        @(negedge clk);
        rst_n = 1'b1;
        ref_reset();
        #1;
        run(80);
        chk("R2 countdown result", ram[8'h20], 0);
        chk("R2 add overflow byte", ram[8'h10] == 8'h80 || ram[8'h10] != 8'h00, 1);
        chk("R8 base-relative store", ram[8'h45], 8'h5A);
        chk("R9 skipped store", ram[8'h30], 0);
        chk("R11 wrap path executed", ram[8'h55], 5);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 mid-run reset fetch", imem_addr, 0);
        chk("R1 mid-run reset we", dmem_we, 0);
        // random program and data
        for (int i = 0; i < 256; i++) begin
            rom[i] = 24'($urandom);
            ram[i] = 8'($urandom);
        end
        @(negedge clk);
        rst_n = 1'b1;
        ref_reset();
        #1;
        run(4000);

        summary();
        $finish;
    end
endmodule